// File: doc/BRIEF.md
# Stop-Mode Wake Event Source Logic

This block watches a byte-wide GPIO port (port 2) and a nibble-wide port (port 3) and raises a single wake request whenever one of four configured sources is active. The four sources are:

- a level source that selects one pin or one pin combination and compares it with a programmed polarity;
- a second combination selector with its own active level;
- a pin-change monitor on port 2;
- a pin-change monitor on port 3.

The change monitors compare the live pins against a snapshot. The snapshot is taken whenever software reads or writes that port.

Pin inputs are resynchronised before use, and the wake request is a registered level that stays high while the condition holds. Software programs five byte-wide registers through a simple write/read strobe interface. One of these registers also routes the wake request to interrupt line 1 and reports the capture status of the change monitors. After reset every source is disabled.

Top module: `wake_src_top`

## Requirements
- R1: After reset `wake_o`, `irq1_o`, all three status outputs and every readable register are 0.
- R2: `wake_o` is the OR of the four sources. It rises exactly 3 clock edges after a pin change that makes a source active (2 synchroniser flops, then one output flop), and stays high while any source remains active.
- R3: The level register is at address 0. Its mode field is bits [4:2]. Codes 000 and 001 select no source. Codes 010, 011 and 100 select port 3 pin 1, pin 2 and pin 3.
- R4: Level mode 101 is the AND of port 2 pins 3:0. Mode 110 is the AND of port 2 pins 7:0. Mode 111 is the OR of port 2 pins 3:0.
- R5: The level source is active when the selected value equals the polarity bit, which is bit 6 of address 0.
- R6: The level source is inactive whenever any pin it uses is either driven as an output (direction bit 1) or enabled in that port's change monitor.
- R7: Address 1 holds the port 2 change enables. A port 2 read or write strobe snapshots the synchronised port 2 pins and sets `p2_cap_o`. An enabled pin that differs from its snapshot is an active source, and disabled pins are ignored. Writing address 1 clears `p2_cap_o` unless a capture happens in the same cycle.
- R8: Address 3 holds the port 3 change enables in bits [3:0] and behaves as in R7, using the port 3 strobes and `p3_cap_o`.
- R9: Address 2 holds the combination code in bits [2:0] and the active level in bit 3. The source is active when the selected value equals the level. The codes are:
  - 0: no source;
  - 1: p3[0];
  - 2: AND p2[3:0];
  - 3: AND p2[7:4];
  - 4: OR p2[7:4];
  - 5: p2[0] AND p3[1];
  - 6: OR p2[7:0];
  - 7: AND p3[3:0].
- R10: Address 4 bit 0 enables `irq1_o = wake_o`. `cap_wr_o` is set by any port write strobe and cleared by a port read strobe when no write strobe is present. The register reads back as {4'b0, cap_wr, p3_cap, p2_cap, irq_en}.
- R11: With `reg_re_i` high, `reg_rdata_o` combinationally shows the register at `reg_addr_i`:
  - address 0 reads as {0, pol, 0, mode, 00};
  - address 2 reads as {0000, level, code};
  - unmapped addresses read 0.
  With `reg_re_i` low, `reg_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| p2_pins_i | input | 8 | Port 2 pin levels (asynchronous) |
| p3_pins_i | input | 4 | Port 3 pin levels (asynchronous) |
| p2_dir_out_i | input | 8 | Port 2 direction, 1 = output |
| p3_dir_out_i | input | 4 | Port 3 direction, 1 = output |
| p2_rd_i | input | 1 | Port 2 read strobe |
| p2_wr_i | input | 1 | Port 2 write strobe |
| p3_rd_i | input | 1 | Port 3 read strobe |
| p3_wr_i | input | 1 | Port 3 write strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| wake_o | output | 1 | Wake event level |
| irq1_o | output | 1 | Wake routed to interrupt line 1 |
| p2_cap_o | output | 1 | Port 2 snapshot taken |
| p3_cap_o | output | 1 | Port 3 snapshot taken |
| cap_wr_o | output | 1 | Last snapshot came from a write |

## Verification
Timing differs by path:

- A pin change reaches `wake_o` on the third rising edge after it is driven.
- A register write, or a snapshot strobe, changes `wake_o` on the second edge: one edge to update the register, one for the output flop.
- Status flags change on the first edge.
- `reg_rdata_o` is valid within the same cycle.

The bench model advances by exactly one step per rising edge, so every one of these latencies comes out of the same step order. The registered outputs are compared at each falling edge. Read data is sampled one time unit after the read is driven. Spot checks on specific requirements are taken only after at least four idle edges, which puts them beyond the longest path.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int P2_W   = 8;
  localparam int P3_W   = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LVL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CHG2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CHG3 = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int LVL_POL_BIT = 6;

  typedef enum logic [2:0] {
    LVL_NONE     = 3'd0,
    LVL_RSVD     = 3'd1,
    LVL_P3_1     = 3'd2,
    LVL_P3_2     = 3'd3,
    LVL_P3_3     = 3'd4,
    LVL_P2_AND_L = 3'd5,
    LVL_P2_AND_A = 3'd6,
    LVL_P2_OR_L  = 3'd7
  } lvl_mode_e;

  typedef enum logic [2:0] {
    CMB_NONE     = 3'd0,
    CMB_P3_0     = 3'd1,
    CMB_P2_AND_L = 3'd2,
    CMB_P2_AND_H = 3'd3,
    CMB_P2_OR_H  = 3'd4,
    CMB_P2P3_MIX = 3'd5,
    CMB_P2_OR_A  = 3'd6,
    CMB_P3_AND_A = 3'd7
  } cmb_code_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= '0;
        else         st_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= '0;
        else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/wake_chg_mon.sv
module wake_chg_mon #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] en_i,
  input  logic         cap_i,
  input  logic         clr_i,
  output logic         evt_o,
  output logic         cap_flag_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      cap_flag_o <= 1'b0;
    end else begin
      if (cap_i) snap_q <= pins_i;
      // capture wins over a clearing register write
      if (cap_i)      cap_flag_o <= 1'b1;
      else if (clr_i) cap_flag_o <= 1'b0;
    end
  end

  assign evt_o = |(en_i & (pins_i ^ snap_q));
endmodule

// File: rtl/wake_level_sel.sv
module wake_level_sel import wake_pkg::*; (
  input  lvl_mode_e         mode_i,
  input  logic              pol_i,
  input  logic [P2_W-1:0]   p2_i,
  input  logic [P2_W-1:0]   mask2_i,
  input  logic [P3_W-1:1]   p3_i,
  input  logic [P3_W-1:1]   mask3_i,
  output logic              active_o
);
  logic val, ok;

  always_comb begin
    val = 1'b0;
    ok  = 1'b0;
    unique case (mode_i)
      LVL_P3_1:     begin val = p3_i[1];     ok = !mask3_i[1];     end
      LVL_P3_2:     begin val = p3_i[2];     ok = !mask3_i[2];     end
      LVL_P3_3:     begin val = p3_i[3];     ok = !mask3_i[3];     end
      LVL_P2_AND_L: begin val = &p2_i[3:0];  ok = ~|mask2_i[3:0];  end
      LVL_P2_AND_A: begin val = &p2_i;       ok = ~|mask2_i;       end
      LVL_P2_OR_L:  begin val = |p2_i[3:0];  ok = ~|mask2_i[3:0];  end
      default:      begin val = 1'b0;        ok = 1'b0;            end
    endcase
    active_o = ok && (val == pol_i);
  end
endmodule

// File: rtl/wake_combo_sel.sv
module wake_combo_sel import wake_pkg::*; (
  input  cmb_code_e         code_i,
  input  logic              lvl_i,
  input  logic [P2_W-1:0]   p2_i,
  input  logic [P3_W-1:0]   p3_i,
  output logic              active_o
);
  logic val, ok;

  always_comb begin
    val = 1'b0;
    ok  = 1'b1;
    unique case (code_i)
      CMB_P3_0:     val = p3_i[0];
      CMB_P2_AND_L: val = &p2_i[3:0];
      CMB_P2_AND_H: val = &p2_i[7:4];
      CMB_P2_OR_H:  val = |p2_i[7:4];
      CMB_P2P3_MIX: val = p2_i[0] & p3_i[1];
      CMB_P2_OR_A:  val = |p2_i;
      CMB_P3_AND_A: val = &p3_i;
      default:      ok  = 1'b0;
    endcase
    active_o = ok && (val == lvl_i);
  end
endmodule

// File: rtl/wake_src_top.sv
module wake_src_top import wake_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [P2_W-1:0]   p2_pins_i,
  input  logic [P3_W-1:0]   p3_pins_i,
  input  logic [P2_W-1:0]   p2_dir_out_i,
  input  logic [P3_W-1:0]   p3_dir_out_i,
  input  logic              p2_rd_i,
  input  logic              p2_wr_i,
  input  logic              p3_rd_i,
  input  logic              p3_wr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wake_o,
  output logic              irq1_o,
  output logic              p2_cap_o,
  output logic              p3_cap_o,
  output logic              cap_wr_o
);
  lvl_mode_e       lvl_mode_q;
  logic            lvl_pol_q;
  logic [P2_W-1:0] chg2_en_q;
  logic [P3_W-1:0] chg3_en_q;
  cmb_code_e       cmb_code_q;
  logic            cmb_lvl_q;
  logic            irq_en_q;
  logic            cap_wr_q;
  logic            wake_q;

  logic [P2_W-1:0] p2_s;
  logic [P3_W-1:0] p3_s;
  logic            lvl_act, cmb_act, chg2_evt, chg3_evt;

  wake_sync #(.W(P2_W), .STAGES(SYNC_STAGES)) u_sync2 (
    .clk_i, .rst_ni, .d_i(p2_pins_i), .q_o(p2_s));
  wake_sync #(.W(P3_W), .STAGES(SYNC_STAGES)) u_sync3 (
    .clk_i, .rst_ni, .d_i(p3_pins_i), .q_o(p3_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_mode_q <= LVL_NONE;
      lvl_pol_q  <= 1'b0;
      chg2_en_q  <= '0;
      chg3_en_q  <= '0;
      cmb_code_q <= CMB_NONE;
      cmb_lvl_q  <= 1'b0;
      irq_en_q   <= 1'b0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        A_LVL: begin
          lvl_mode_q <= lvl_mode_e'(reg_wdata_i[4:2]);
          lvl_pol_q  <= reg_wdata_i[LVL_POL_BIT];
        end
        A_CHG2: chg2_en_q <= reg_wdata_i;
        A_CMB: begin
          cmb_code_q <= cmb_code_e'(reg_wdata_i[2:0]);
          cmb_lvl_q  <= reg_wdata_i[3];
        end
        A_CHG3: chg3_en_q <= reg_wdata_i[P3_W-1:0];
        A_STAT: irq_en_q  <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  wake_chg_mon #(.W(P2_W)) u_chg2 (
    .clk_i, .rst_ni, .pins_i(p2_s), .en_i(chg2_en_q),
    .cap_i(p2_rd_i | p2_wr_i),
    .clr_i(reg_we_i && reg_addr_i == A_CHG2),
    .evt_o(chg2_evt), .cap_flag_o(p2_cap_o));

  wake_chg_mon #(.W(P3_W)) u_chg3 (
    .clk_i, .rst_ni, .pins_i(p3_s), .en_i(chg3_en_q),
    .cap_i(p3_rd_i | p3_wr_i),
    .clr_i(reg_we_i && reg_addr_i == A_CHG3),
    .evt_o(chg3_evt), .cap_flag_o(p3_cap_o));

  // pins owned by a change monitor or driven as outputs are hidden from the level source
  wake_level_sel u_lvl (
    .mode_i(lvl_mode_q), .pol_i(lvl_pol_q),
    .p2_i(p2_s), .mask2_i(p2_dir_out_i | chg2_en_q),
    .p3_i(p3_s[P3_W-1:1]), .mask3_i(p3_dir_out_i[P3_W-1:1] | chg3_en_q[P3_W-1:1]),
    .active_o(lvl_act));

  wake_combo_sel u_cmb (
    .code_i(cmb_code_q), .lvl_i(cmb_lvl_q),
    .p2_i(p2_s), .p3_i(p3_s), .active_o(cmb_act));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q   <= 1'b0;
      cap_wr_q <= 1'b0;
    end else begin
      wake_q <= lvl_act | cmb_act | chg2_evt | chg3_evt;
      if (p2_wr_i | p3_wr_i)      cap_wr_q <= 1'b1;
      else if (p2_rd_i | p3_rd_i) cap_wr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      unique case (reg_addr_i)
        A_LVL:  reg_rdata_o = {1'b0, lvl_pol_q, 1'b0, lvl_mode_q, 2'b00};
        A_CHG2: reg_rdata_o = chg2_en_q;
        A_CMB:  reg_rdata_o = {4'b0, cmb_lvl_q, cmb_code_q};
        A_CHG3: reg_rdata_o = {{(DATA_W-P3_W){1'b0}}, chg3_en_q};
        A_STAT: reg_rdata_o = {4'b0, cap_wr_q, p3_cap_o, p2_cap_o, irq_en_q};
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign wake_o   = wake_q;
  assign irq1_o   = wake_q & irq_en_q;
  assign cap_wr_o = cap_wr_q;
endmodule

// File: rtl/wake_src_chk.sv
module wake_src_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       p2_rd_i,
  input logic       p2_wr_i,
  input logic       p3_rd_i,
  input logic       p3_wr_i,
  input logic       reg_re_i,
  input logic [7:0] reg_rdata_o,
  input logic       wake_o,
  input logic       irq1_o,
  input logic       p2_cap_o,
  input logic       p3_cap_o,
  input logic       cap_wr_o,
  input logic       cfg_any_i
);
  p_wake_needs_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(cfg_any_i));

  p_cap2_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p2_cap_o) |-> $past(p2_rd_i || p2_wr_i));

  p_cap3_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p3_cap_o) |-> $past(p3_rd_i || p3_wr_i));

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_o |-> wake_o);

  p_capwr_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_wr_o) |-> $past(p2_wr_i || p3_wr_i));

  p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |-> reg_rdata_o == 8'h00);
endmodule

bind wake_src_top wake_src_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .p2_rd_i(p2_rd_i), .p2_wr_i(p2_wr_i), .p3_rd_i(p3_rd_i), .p3_wr_i(p3_wr_i),
  .reg_re_i(reg_re_i), .reg_rdata_o(reg_rdata_o),
  .wake_o(wake_o), .irq1_o(irq1_o),
  .p2_cap_o(p2_cap_o), .p3_cap_o(p3_cap_o), .cap_wr_o(cap_wr_o),
  .cfg_any_i(lvl_mode_q > 3'd1 || (|chg2_en_q) || (|chg3_en_q) || cmb_code_q != 3'd0));

// File: tb/wake_src_top_tb.sv
`timescale 1ns/1ps
module wake_src_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] p2 = '0, dir2 = '0;
  logic [3:0] p3 = '0, dir3 = '0;
  logic       p2_rd = 0, p2_wr = 0, p3_rd = 0, p3_wr = 0;
  logic       we = 0, re = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wake, irq1, cap2, cap3, capwr;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  wake_src_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .p2_pins_i(p2), .p3_pins_i(p3), .p2_dir_out_i(dir2), .p3_dir_out_i(dir3),
    .p2_rd_i(p2_rd), .p2_wr_i(p2_wr), .p3_rd_i(p3_rd), .p3_wr_i(p3_wr),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wake_o(wake), .irq1_o(irq1),
    .p2_cap_o(cap2), .p3_cap_o(cap3), .cap_wr_o(capwr));

  // ---------------- reference model ----------------
  logic [7:0] m2a, m2b, m_en2, m_snap2;
  logic [3:0] m3a, m3b, m_en3, m_snap3;
  int         m_mode, m_code;
  bit         m_pol, m_lvl, m_irq, m_cap2, m_cap3, m_capwr, m_wake;

  function automatic bit all1(input logic [7:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) if (!v[i]) return 0;
    return 1;
  endfunction
  function automatic bit any1(input logic [7:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) if (v[i]) return 1;
    return 0;
  endfunction

  function automatic bit m_level();
    logic [7:0] mk2 = dir2 | m_en2;
    logic [7:0] mk3 = {4'b0, dir3 | m_en3};
    logic [7:0] q3 = {4'b0, m3b};
    bit v; bit ok;
    case (m_mode)
      2: begin v = q3[1]; ok = !mk3[1]; end
      3: begin v = q3[2]; ok = !mk3[2]; end
      4: begin v = q3[3]; ok = !mk3[3]; end
      5: begin v = all1(m2b, 0, 3); ok = !any1(mk2, 0, 3); end
      6: begin v = all1(m2b, 0, 7); ok = !any1(mk2, 0, 7); end
      7: begin v = any1(m2b, 0, 3); ok = !any1(mk2, 0, 3); end
      default: begin v = 0; ok = 0; end
    endcase
    return ok && (v == m_pol);
  endfunction

  function automatic bit m_combo();
    logic [7:0] q3 = {4'b0, m3b};
    bit v;
    case (m_code)
      1: v = q3[0];
      2: v = all1(m2b, 0, 3);
      3: v = all1(m2b, 4, 7);
      4: v = any1(m2b, 4, 7);
      5: v = m2b[0] && q3[1];
      6: v = any1(m2b, 0, 7);
      7: v = all1(q3, 0, 3);
      default: return 0;
    endcase
    return v == m_lvl;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_pol, 1'b0, 3'(m_mode), 2'b00};
      3'd1: return m_en2;
      3'd2: return {4'b0, m_lvl, 3'(m_code)};
      3'd3: return {4'b0, m_en3};
      3'd4: return {4'b0, m_capwr, m_cap3, m_cap2, m_irq};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m2a = 0; m2b = 0; m3a = 0; m3b = 0; m_en2 = 0; m_en3 = 0;
      m_snap2 = 0; m_snap3 = 0; m_mode = 0; m_code = 0; m_pol = 0; m_lvl = 0;
      m_irq = 0; m_cap2 = 0; m_cap3 = 0; m_capwr = 0; m_wake = 0;
    end else begin
      bit nw;
      nw = m_level() || m_combo() || ((m_en2 & (m2b ^ m_snap2)) != 0)
           || ((m_en3 & (m3b ^ m_snap3)) != 0);
      if (p2_rd || p2_wr) begin m_snap2 = m2b; m_cap2 = 1; end
      else if (we && addr == 3'd1) m_cap2 = 0;
      if (p3_rd || p3_wr) begin m_snap3 = m3b; m_cap3 = 1; end
      else if (we && addr == 3'd3) m_cap3 = 0;
      if (p2_wr || p3_wr) m_capwr = 1;
      else if (p2_rd || p3_rd) m_capwr = 0;
      if (we) case (addr)
        3'd0: begin m_mode = int'(wdata[4:2]); m_pol = wdata[6]; end
        3'd1: m_en2 = wdata;
        3'd2: begin m_code = int'(wdata[2:0]); m_lvl = wdata[3]; end
        3'd3: m_en3 = wdata[3:0];
        3'd4: m_irq = wdata[0];
        default: ;
      endcase
      m2b = m2a; m2a = p2; m3b = m3a; m3a = p3;
      m_wake = nw;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2",  "wake_o",   {7'b0, wake},  {7'b0, m_wake});
    check("R10", "irq1_o",   {7'b0, irq1},  {7'b0, m_wake && m_irq});
    check("R7",  "p2_cap_o", {7'b0, cap2},  {7'b0, m_cap2});
    check("R8",  "p3_cap_o", {7'b0, cap3},  {7'b0, m_cap3});
    check("R10", "cap_wr_o", {7'b0, capwr}, {7'b0, m_capwr});
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask
  task automatic rd(input string req, input logic [2:0] a);
    @(negedge clk); re = 1; addr = a;
    #1 check(req, "reg_rdata_o", rdata, m_read(a));
    @(negedge clk); re = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic strobe(input int which);
    @(negedge clk);
    case (which) 0: p2_rd = 1; 1: p2_wr = 1; 2: p3_rd = 1; default: p3_wr = 1; endcase
    @(negedge clk); p2_rd = 0; p2_wr = 0; p3_rd = 0; p3_wr = 0;
  endtask
  task automatic expect_wake(input string req, input bit e);
    idle(4);
    check(req, "settled wake_o", {7'b0, wake}, {7'b0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    idle(1);
    check("R1", "wake_o", {7'b0, wake}, 8'h00);
    check("R1", "status", {5'b0, capwr, cap3, cap2}, 8'h00);
    for (int a = 0; a < 5; a++) rd("R1", 3'(a));

    // R3 port 3 pin modes and null codes
    wr(0, 8'h48); @(negedge clk); p3 = 4'b0010; expect_wake("R3", 1);
    p3 = 4'b0000; expect_wake("R3", 0);
    p3 = 4'b0010;
    wr(0, 8'h40); expect_wake("R3", 0);        // code 000
    wr(0, 8'h44); expect_wake("R3", 0);        // code 001
    wr(0, 8'h4C); @(negedge clk); p3 = 4'b0100; expect_wake("R3", 1);
    wr(0, 8'h50); @(negedge clk); p3 = 4'b1000; expect_wake("R3", 1);
    // R5 polarity low
    wr(0, 8'h08); @(negedge clk); p3 = 4'b0000; expect_wake("R5", 1);
    p3 = 4'b0010; expect_wake("R5", 0);
    // R2 latency: due on the third edge after the pin change
    @(negedge clk); p3 = 4'b0000;
    @(negedge clk); check("R2", "latency e1", {7'b0, wake}, 8'h00);
    @(negedge clk); check("R2", "latency e2", {7'b0, wake}, 8'h00);
    @(negedge clk); check("R2", "latency e3", {7'b0, wake}, 8'h01);
    p3 = 4'b0010;

    // R4 port 2 combinations
    wr(0, 8'h54); @(negedge clk); p2 = 8'h0F; expect_wake("R4", 1);
    p2 = 8'h07; expect_wake("R4", 0);
    wr(0, 8'h58); @(negedge clk); p2 = 8'hFF; expect_wake("R4", 1);
    p2 = 8'h7F; expect_wake("R4", 0);
    wr(0, 8'h5C); @(negedge clk); p2 = 8'h01; expect_wake("R4", 1);
    p2 = 8'hF0; expect_wake("R4", 0);

    // R6 masking
    wr(0, 8'h54); @(negedge clk); p2 = 8'h0F; expect_wake("R6", 1);
    dir2 = 8'h01; expect_wake("R6", 0);
    dir2 = 8'h00; expect_wake("R6", 1);
    strobe(0);                                  // snapshot equals pins
    wr(1, 8'h02); expect_wake("R6", 0);
    wr(1, 8'h00); expect_wake("R6", 1);
    wr(0, 8'h00); expect_wake("R6", 0);

    // R7 port 2 change monitor
    @(negedge clk); p2 = 8'hA5; idle(3);
    wr(1, 8'hFF); strobe(0); expect_wake("R7", 0);
    check("R7", "p2_cap_o", {7'b0, cap2}, 8'h01);
    check("R10", "cap_wr_o read", {7'b0, capwr}, 8'h00);
    p2 = 8'hE5; expect_wake("R7", 1);
    strobe(1); expect_wake("R7", 0);
    check("R10", "cap_wr_o write", {7'b0, capwr}, 8'h01);
    wr(1, 8'hFE);
    check("R7", "p2_cap_o cleared", {7'b0, cap2}, 8'h00);
    p2 = 8'hE4; expect_wake("R7", 0);          // disabled pin ignored
    wr(1, 8'h00);

    // R8 port 3 change monitor
    wr(3, 8'h0F); strobe(2); expect_wake("R8", 0);
    check("R8", "p3_cap_o", {7'b0, cap3}, 8'h01);
    p3 = 4'b1010; expect_wake("R8", 1);
    strobe(3); expect_wake("R8", 0);
    wr(3, 8'h00);

    // R9 combination selector
    p2 = 8'h00; p3 = 4'b0001;
    wr(2, 8'h09); expect_wake("R9", 1);        // code1 p3[0] lvl1
    wr(2, 8'h02); expect_wake("R9", 1);        // code2 lvl0, p2 low nibble 0
    @(negedge clk); p2 = 8'hF0;
    wr(2, 8'h0B); expect_wake("R9", 1);        // code3 lvl1
    @(negedge clk); p2 = 8'h0F;
    wr(2, 8'h04); expect_wake("R9", 1);        // code4 lvl0
    @(negedge clk); p2 = 8'h01; p3 = 4'b0010;
    wr(2, 8'h0D); expect_wake("R9", 1);        // code5 lvl1
    @(negedge clk); p2 = 8'h00;
    wr(2, 8'h06); expect_wake("R9", 1);        // code6 lvl0
    @(negedge clk); p3 = 4'b1111;
    wr(2, 8'h0F); expect_wake("R9", 1);        // code7 lvl1
    wr(2, 8'h08); expect_wake("R9", 0);        // code0

    // R2 OR of two sources
    wr(2, 8'h0F); wr(0, 8'h48); expect_wake("R2", 1);
    wr(2, 8'h00); expect_wake("R2", 1);
    wr(0, 8'h00); expect_wake("R2", 0);

    // R10 interrupt routing
    wr(2, 8'h0F); wr(4, 8'h01); idle(4);
    check("R10", "irq1_o on", {7'b0, irq1}, 8'h01);
    wr(4, 8'h00); idle(2);
    check("R10", "irq1_o off", {7'b0, irq1}, 8'h00);
    rd("R10", 3'd4);

    // R11 readback
    wr(0, 8'hFF); wr(1, 8'h3C); wr(3, 8'hF5);
    for (int a = 0; a < 8; a++) rd("R11", 3'(a));
    @(negedge clk); addr = 3'd1;
    #1 check("R11", "rdata with re low", rdata, 8'h00);

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule